// File: doc/BRIEF.md
# Dual-Mode Magnitude Comparator

This block compares two operands of equal width and raises exactly one of three flags: first operand greater, first operand less, or both equal. A single mode input chooses how the operand bits are read. When the mode is low, both operands are plain unsigned binary numbers, and this is the default reading. When the mode is high, both operands are two's complement numbers. In that case the top bit carries the negative weight -2^(W-1), which is -8 at the default width of 4.

Only one unsigned comparison core exists. It works through bit pairs from the most significant position down to bit 0. A lower position decides the result only when every position above it matches. Before an operand reaches the core, its top bit is XORed with the mode bit, and the lower bits pass through untouched. Flipping both top bits adds half the range to both values. This moves the signed range onto the unsigned range and keeps the order of the values, so the same core gives the signed answer.

The block is purely combinational. It has no clock and no storage, and its flags follow the current inputs.

Top module: `dual_mode_cmp`

## Requirements
- R1: With `signed_mode` = 0, `a_gt` is 1 exactly when `op_a` > `op_b` read as unsigned integers, and `a_lt` is 1 exactly when `op_a` < `op_b` read as unsigned integers.
- R2: With `signed_mode` = 1, `a_gt` and `a_lt` follow the two's complement order of the operands, in which bit W-1 has weight -2^(W-1).
- R3: For every input combination, exactly one of `a_gt`, `a_lt` and `a_eq` is 1.
- R4: `a_eq` is 1 exactly when `op_a` and `op_b` are bit-for-bit identical, in either mode.
- R5: At W = 4, operands 4'b1000 and 4'b0111 give `a_gt` = 1 in unsigned mode (8 > 7) and `a_lt` = 1 in signed mode (-8 < 7).
- R6: When the top bits of the two operands are equal, the three flags are the same in both modes.
- R7: The flags depend only on the present inputs. They settle without any clock edge after an input changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | W | First operand |
| op_b | input | W | Second operand |
| signed_mode | input | 1 | 0 = unsigned, 1 = two's complement |
| a_gt | output | 1 | op_a greater than op_b |
| a_lt | output | 1 | op_a less than op_b |
| a_eq | output | 1 | op_a equal to op_b |

## Verification
The bench builds the comparator with its default width of 4. At that width all 512 combinations of both operands and the mode can be applied in turn, so every sign pairing and every position of the deciding bit is covered. The most negative versus most positive corner is checked both ways. Random patterns from a fixed seed then revisit the space with mode flips between samples. This shows that a result never carries over from the previous input.

// File: rtl/dual_mode_cmp_pkg.sv
package dual_mode_cmp_pkg;
    typedef struct packed {
        logic gt;
        logic lt;
        logic eq;
    } cmp_flags_t;
endpackage

// File: rtl/cmp_sign_cond.sv
module cmp_sign_cond #(
    parameter int W = 4
) (
    input  logic [W-1:0] raw,
    input  logic         mode,
    output logic [W-1:0] cond
);
    localparam int TOP = W - 1;

    always_comb begin
        cond      = raw;
        cond[TOP] = raw[TOP] ^ mode;
    end
endmodule

// File: rtl/cmp_ucore.sv
module cmp_ucore
    import dual_mode_cmp_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output cmp_flags_t   flags
);
    logic [W-1:0] same_bit;

    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_xnor
            assign same_bit[g] = ~(x[g] ^ y[g]);
        end
    endgenerate

    cmp_flags_t flags_d;

    always_comb begin
        logic above_same;
        above_same = 1'b1;
        flags_d    = '0;
        for (int i = W - 1; i >= 0; i--) begin
            flags_d.gt = flags_d.gt | (above_same & x[i] & ~y[i]);
            flags_d.lt = flags_d.lt | (above_same & ~x[i] & y[i]);
            above_same = above_same & same_bit[i];
        end
        flags_d.eq = above_same;
    end

    assign flags = flags_d;
endmodule

// File: rtl/dual_mode_cmp.sv
module dual_mode_cmp
    import dual_mode_cmp_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         signed_mode,
    output logic         a_gt,
    output logic         a_lt,
    output logic         a_eq
);
    localparam int TOP = W - 1;

    logic [W-1:0] a_cond;
    logic [W-1:0] b_cond;
    cmp_flags_t   core_flags;

    cmp_sign_cond #(.W(W)) u_cond_a (.raw(op_a), .mode(signed_mode), .cond(a_cond));
    cmp_sign_cond #(.W(W)) u_cond_b (.raw(op_b), .mode(signed_mode), .cond(b_cond));

    cmp_ucore #(.W(W)) u_core (.x(a_cond), .y(b_cond), .flags(core_flags));

    assign a_gt = core_flags.gt;
    assign a_lt = core_flags.lt;
    assign a_eq = core_flags.eq;

    always_comb begin
        assert_one_hot_R3: assert ($onehot({a_gt, a_lt, a_eq}))
            else $error("R3 flags not one-hot");
        assert_eq_match_R4: assert (a_eq == (op_a == op_b))
            else $error("R4 equality flag mismatch");
        if (op_a[TOP] == op_b[TOP]) begin
            assert_same_sign_R6: assert (a_gt == (op_a > op_b))
                else $error("R6 same-sign result depends on mode");
        end
        if (signed_mode && (op_a[TOP] != op_b[TOP])) begin
            assert_sign_decides_R2: assert (a_gt == op_b[TOP])
                else $error("R2 mixed-sign signed result wrong");
        end
    end
endmodule

// File: tb/dual_mode_cmp_bench.sv
`timescale 1ns/1ps
module dual_mode_cmp_bench;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         signed_mode = 1'b0;
    logic         a_gt, a_lt, a_eq;
    int           checks = 0;
    int           errors = 0;
    bit           done = 1'b0;

    always #10 clk = ~clk;

    dual_mode_cmp #(.W(W)) u_dual_mode_cmp (
        .op_a(op_a), .op_b(op_b), .signed_mode(signed_mode),
        .a_gt(a_gt), .a_lt(a_lt), .a_eq(a_eq)
    );

    function automatic int to_int(input logic [W-1:0] v, input logic sm);
        int r;
        r = int'(v);
        if (sm && v[W-1]) r = r - (1 << W);
        return r;
    endfunction

    function automatic logic [2:0] expect_flags(input logic [W-1:0] a, input logic [W-1:0] b,
                                                input logic sm);
        int ia, ib;
        ia = to_int(a, sm);
        ib = to_int(b, sm);
        return {ia > ib, ia < ib, ia == ib};
    endfunction

    task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s a=%b b=%b mode=%b actual gt/lt/eq=%b expected=%b",
                     req, op_a, op_b, signed_mode, got, exp);
        end
    endtask

    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic sm);
        @(negedge clk);
        op_a = a;
        op_b = b;
        signed_mode = sm;
        #1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        int unsigned seed;
        logic [2:0] r_u, r_s;
        seed = 32'd20240511;

        apply('0, '0, 1'b0);
        check("R4 reset-state zero inputs", {a_gt, a_lt, a_eq}, 3'b001);

        // R5 corner cases
        apply(4'b1000, 4'b0111, 1'b0);
        check("R5 unsigned 8>7", {a_gt, a_lt, a_eq}, 3'b100);
        apply(4'b1000, 4'b0111, 1'b1);
        check("R5 signed -8<7", {a_gt, a_lt, a_eq}, 3'b010);
        apply(4'b0111, 4'b1000, 1'b1);
        check("R5 signed 7>-8", {a_gt, a_lt, a_eq}, 3'b100);

        // exhaustive R1 R2 R3 R4
        for (int m = 0; m < 2; m++) begin
            for (int a = 0; a < (1 << W); a++) begin
                for (int b = 0; b < (1 << W); b++) begin
                    apply(W'(a), W'(b), m[0]);
                    if (m == 0) check("R1 unsigned order", {a_gt, a_lt, a_eq},
                                      expect_flags(W'(a), W'(b), 1'b0));
                    else        check("R2 signed order", {a_gt, a_lt, a_eq},
                                      expect_flags(W'(a), W'(b), 1'b1));
                    check("R3 one-hot", 3'(($countones({a_gt, a_lt, a_eq}) == 1) ? 1 : 0), 3'd1);
                    check("R4 equality", {2'b00, a_eq}, {2'b00, a == b});
                end
            end
        end

        // R6 same-sign independence, R7 immediate follow with mode flips
        for (int k = 0; k < 300; k++) begin
            logic [W-1:0] ra, rb;
            ra = W'($urandom(seed));
            seed = seed + 32'd7919;
            rb = W'($urandom(seed));
            seed = seed + 32'd104729;
            apply(ra, rb, 1'b0);
            r_u = {a_gt, a_lt, a_eq};
            check("R7 unsigned settle", r_u, expect_flags(ra, rb, 1'b0));
            signed_mode = 1'b1;
            #1;
            r_s = {a_gt, a_lt, a_eq};
            check("R7 signed settle after mode flip", r_s, expect_flags(ra, rb, 1'b1));
            if (ra[W-1] == rb[W-1]) check("R6 mode independence same sign", r_s, r_u);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule